// File: doc/BRIEF.md
# Stepped Soft-Start Current Reference

This block generates the digital charge-current reference a charger's current loop follows while fast charge begins. When fast charge is entered, the reference does not jump to the programmed value. It climbs in eight equal increments, starting from zero. Each increment is held for a fixed number of clock cycles, set by the parameter `DWELL_CYCLES`. After the eighth increment, the reference sits at the programmed setpoint and a done flag rises. Both stay that way until charging is disabled or fast charge is entered again.

Every input and output is a level or a single-cycle strobe. No data stream crosses the block, so the block has no valid/ready handshake and nothing to back-pressure. The reference is computed combinationally from the registered step index and the live setpoint word. The current step is `k`, from 0 to 8, and the output is `floor(setpt * k / 8)`. Clearing the enable forces the output to zero in the same cycle. On the next clock edge the step index returns to zero.

Top module: `softstart_ramp`

## Requirements
- R1: While reset is asserted and after reset is released, `iref` is 0 and `ramp_done` is 0.
- R2: A one-cycle `fc_entry` pulse sampled with `charge_en` high sets the step to 1 at that clock edge, so `iref` equals `floor(setpt/8)` in the cycle that follows.
- R3: Step k (1..8) drives `iref = floor(setpt*k/8)`. Steps 1 to 7 each last exactly `DWELL_CYCLES` cycles before the next step begins.
- R4: In the same cycle that step 8 is reached, `iref` equals `setpt` exactly and `ramp_done` is 1. Both hold for as long as `charge_en` stays high and no new `fc_entry` arrives.
- R5: `iref` never exceeds `setpt`.
- R6: With `charge_en` low, `iref` is 0 and `ramp_done` is 0 in that same cycle. The ramp is aborted, and `iref` stays 0 after `charge_en` returns high until a new `fc_entry` arrives.
- R7: An `fc_entry` pulse during a ramp, or after the ramp is done, restarts the ramp at step 1.
- R8: After `ramp_done`, a change of `setpt` shows on `iref` in the same cycle, with no new ramp and no change of `ramp_done`.
- R9: An `fc_entry` pulse sampled while `charge_en` is low is ignored. `iref` is still 0 after `charge_en` returns high.
- R10: With `charge_en` high and no `fc_entry` seen since reset or since the last disable, `iref` is 0 and `ramp_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| charge_en | input | 1 | Charging allowed; low aborts and zeroes the ramp |
| fc_entry | input | 1 | One-cycle strobe marking entry into fast charge |
| setpt | input | SP_W | Programmed charge current setpoint |
| iref | output | SP_W | Current regulation reference |
| ramp_done | output | 1 | High once the eighth step is reached |

## Verification
On every cycle the assertions check the following:
- the reference never exceeds the setpoint;
- step 8 gives exactly the setpoint;
- a disable clears the step index, and an accepted entry strobe lands on step 1;
- the step index only holds or rises by one, and holds once it reaches step 8;
- the dwell counter stays below its limit.

Only the bench scenarios can show the rest: that each step lasts exactly the dwell length, and that the staircase values are correct for several setpoints, including ones not divisible by eight. They also show that a setpoint change after the ramp takes effect at once, and that a strobe seen while disabled leaves no trace.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);
  localparam int STEP_SH   = $clog2(NUM_STEPS);
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer #(
  parameter int DWELL_CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (run_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && !clear_i && (cnt_q == LAST);

  // R3: dwell counter never passes its final value
  p_dwell_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ss_step_ctr.sv
module ss_step_ctr
  import softstart_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  entry_i,
  input  logic  tick_i,
  output step_t step_o,
  output logic  run_o
);
  localparam step_t TOP = STEP_W'(NUM_STEPS);

  step_t step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    step_q <= '0;
    else if (!en_i)                                step_q <= '0;
    else if (entry_i)                              step_q <= STEP_W'(1);
    else if (tick_i && step_q != '0 && step_q < TOP) step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;
  assign run_o  = en_i && (step_q != '0) && (step_q < TOP);

  // R6: a disable clears the ramp on the next edge
  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> step_q == '0);
  // R7: an accepted entry strobe lands on step 1
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && entry_i |=> step_q == STEP_W'(1));
  // R3: without a strobe the step only holds or advances by one
  p_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !entry_i |=> (step_q == $past(step_q)) || (step_q == $past(step_q) + 1'b1));
  // R4: the final step is held
  p_hold_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !entry_i && step_q == TOP |=> step_q == TOP);
  // R10: no ramp starts without a strobe
  p_no_self_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_q == '0 && !entry_i |=> step_q == '0);
endmodule

// File: rtl/ss_ref_scale.sv
module ss_ref_scale
  import softstart_pkg::*;
#(
  parameter int SP_W = 12
) (
  input  logic [SP_W-1:0] setpt_i,
  input  step_t           step_i,
  output logic [SP_W-1:0] ref_o
);
  localparam int PW = SP_W + STEP_W;

  logic [PW-1:0] prod;

  always_comb begin
    prod  = PW'(setpt_i) * PW'(step_i);
    ref_o = SP_W'(prod >> STEP_SH);
  end

  always_comb begin
    // R5: scaled value never above the setpoint
    p_no_overshoot_r5: assert (ref_o <= setpt_i);
    // R4: last step reproduces the setpoint exactly
    if (step_i == STEP_W'(NUM_STEPS))
      p_final_exact_r4: assert (ref_o == setpt_i);
  end
endmodule

// File: rtl/softstart_ramp.sv
module softstart_ramp
  import softstart_pkg::*;
#(
  parameter int SP_W         = 12,
  parameter int DWELL_CYCLES = 80000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            charge_en,
  input  logic            fc_entry,
  input  logic [SP_W-1:0] setpt,
  output logic [SP_W-1:0] iref,
  output logic            ramp_done
);
  step_t           step;
  logic            run;
  logic            tick;
  logic [SP_W-1:0] scaled;

  ss_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n),
    .clear_i(!charge_en || fc_entry),
    .run_i(run), .tick_o(tick)
  );

  ss_step_ctr step_i (
    .clk(clk), .rst_n(rst_n), .en_i(charge_en), .entry_i(fc_entry),
    .tick_i(tick), .step_o(step), .run_o(run)
  );

  ss_ref_scale #(.SP_W(SP_W)) scale_i (
    .setpt_i(setpt), .step_i(step), .ref_o(scaled)
  );

  assign iref      = charge_en ? scaled : '0;
  assign ramp_done = charge_en && (step == STEP_W'(NUM_STEPS));

  // R4: done implies the reference sits on the setpoint
  p_done_at_setpt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> iref == setpt);
  // R6: disabled means quiet outputs
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !charge_en |-> (iref == '0) && !ramp_done);
endmodule

// File: tb/softstart_ramp_tb_top.sv
`timescale 1ns/1ps
module softstart_ramp_tb_top;
  localparam int SP_W  = 12;
  localparam int DWELL = 4;
  localparam int NV    = 6;
  localparam logic [SP_W-1:0] SP_TAB [NV] = '{12'd0, 12'd7, 12'd8, 12'd1000, 12'd4095, 12'd2049};

  logic clk = 0, rst_n = 0, charge_en = 0, fc_entry = 0;
  logic [SP_W-1:0] setpt = '0;
  logic [SP_W-1:0] iref;
  logic ramp_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  softstart_ramp #(.SP_W(SP_W), .DWELL_CYCLES(DWELL)) dut_i (
    .clk(clk), .rst_n(rst_n), .charge_en(charge_en), .fc_entry(fc_entry),
    .setpt(setpt), .iref(iref), .ramp_done(ramp_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic entry_pulse();
    @(negedge clk); fc_entry = 1;
    @(negedge clk); fc_entry = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int stair(input int sp, input int k);
    return (sp * k) / 8;
  endfunction

  initial begin
    wait_n(100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    charge_en = 1; setpt = 12'd800;
    wait_n(3);
    chk("R1", "iref in reset", int'(iref), 0);
    chk("R1", "done in reset", int'(ramp_done), 0);
    rst_n = 1;
    wait_n(2);
    chk("R1", "iref after reset", int'(iref), 0);
    chk("R10", "iref no entry", int'(iref), 0);
    wait_n(10);
    chk("R10", "done no entry", int'(ramp_done), 0);

    // table walk: full staircase for each setpoint
    for (int v = 0; v < NV; v++) begin
      setpt = SP_TAB[v];
      entry_pulse();
      for (int k = 1; k <= 8; k++) begin
        chk(k == 1 ? "R2" : "R3", "step value", int'(iref), stair(int'(SP_TAB[v]), k));
        chk("R5", "no overshoot", int'(iref <= setpt), 1);
        chk("R4", "done flag", int'(ramp_done), (k == 8) ? 1 : 0);
        if (k < 8) begin
          wait_n(DWELL - 1);
          chk("R3", "dwell end", int'(iref), stair(int'(SP_TAB[v]), k));
          wait_n(1);
        end
      end
      chk("R4", "final exact", int'(iref), int'(SP_TAB[v]));
      wait_n(12);
      chk("R4", "hold value", int'(iref), int'(SP_TAB[v]));
      chk("R4", "hold done", int'(ramp_done), 1);
    end

    // R8: setpoint change after done is immediate
    @(negedge clk); setpt = 12'd333; #1;
    chk("R8", "new setpt", int'(iref), 333);
    chk("R8", "done kept", int'(ramp_done), 1);
    wait_n(3);
    chk("R8", "no new ramp", int'(iref), 333);

    // R7: restart after done
    setpt = 12'd1600;
    entry_pulse();
    chk("R7", "restart after done", int'(iref), 200);
    chk("R7", "done cleared", int'(ramp_done), 0);
    wait_n(4 * DWELL);
    chk("R3", "step 5", int'(iref), 1000);
    entry_pulse();
    chk("R7", "restart mid ramp", int'(iref), 200);
    wait_n(7 * DWELL);
    chk("R7", "reaches top again", int'(iref), 1600);
    chk("R7", "done again", int'(ramp_done), 1);

    // R6: disable mid ramp
    entry_pulse();
    wait_n(2 * DWELL);
    chk("R6", "mid ramp value", int'(iref), 600);
    charge_en = 0; #1;
    chk("R6", "iref zero same cycle", int'(iref), 0);
    chk("R6", "done zero", int'(ramp_done), 0);
    wait_n(2);
    charge_en = 1;
    wait_n(2);
    chk("R6", "stays zero after re-enable", int'(iref), 0);
    wait_n(8 * DWELL);
    chk("R6", "no resume", int'(iref), 0);

    // R9: strobe while disabled ignored
    charge_en = 0;
    entry_pulse();
    wait_n(1);
    charge_en = 1;
    wait_n(2);
    chk("R9", "ignored strobe", int'(iref), 0);
    chk("R9", "ignored done", int'(ramp_done), 0);

    // R6: disable after done
    entry_pulse();
    wait_n(7 * DWELL);
    chk("R4", "top before disable", int'(ramp_done), 1);
    charge_en = 0; #1;
    chk("R6", "done drops", int'(ramp_done), 0);
    chk("R6", "iref drops", int'(iref), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule